// File: doc/BRIEF.md
# Exposed-Bypass ALU Execution Stage

This block is the execute stage of a single-issue core that makes forwarding visible to software. It has three functional units: an adder, a barrel shifter and a logic unit. Each unit has its own bypass register. Every cycle the stage may accept one decoded operation, which gives a unit, a 2-bit opcode, a destination register index and two operand selectors. A selector names either a register-file entry or one of the three bypass registers.

An operation's result is loaded into its unit's bypass register at the closing clock edge, so the next operation can use it with no wait. The same result also enters a one-entry write-back slot. From there it is committed to the register file one clock later. There are no interlocks. A read of a register whose write-back is still in flight returns the stale contents, and software is expected to name the bypass register in that case.

The stage presents each operation's result, with a valid strobe, one cycle after issue. The register file has no load port, so all values are built from the reset zeros through the units themselves.

Top module: `bx_alu_stage`

## Requirements
- R1: A synchronous active-high `rst` clears every register-file entry, all three bypass registers, the pending write-back and `res_valid` to zero.
- R2: Adder (`op_unit`=0) opcodes: 0 gives A+B, 1 gives A-B, 2 gives B-A and 3 gives A+B+1, all modulo 2^DATA_W.
- R3: Shifter (`op_unit`=1) shifts A by the low log2(DATA_W) bits of B. Opcode 0 is logical left, 1 is logical right, 2 is arithmetic right and 3 is rotate left. A shift of zero returns A.
- R4: Logic unit (`op_unit`=2) opcodes: 0 gives AND, 1 gives OR, 2 gives XOR and 3 gives NOR.
- R5: Operand selector encoding: if the top bit is 0, the low log2(REG_COUNT) bits index the register file. If the top bit is 1, the two lowest bits pick bypass 0 (adder), 1 (shifter) or 2 (logic), and code 3 reads zero.
- R6: An operation issued in cycle N (`op_valid`=1 and `op_unit`≠3) drives `res_valid`=1 and its result on `res_data` in cycle N+1. In every other case `res_valid` is 0 in the following cycle.
- R7: A unit's bypass register holds the result of that unit's most recent operation. It can be read by the very next operation, and operations on other units leave it unchanged.
- R8: The result of an operation issued in cycle N is written to `op_dst` in the register file. A read of that entry in cycle N+1 returns the old value, and a read in N+2 or later returns the new value.
- R9: Write-back cannot be suppressed. It happens whether or not an operation is issued in cycle N+1. When two back-to-back operations name the same destination, the later result remains.
- R10: A read issued in the same cycle that a bypass register is reloaded, or that a register-file entry is committed, returns the value from before that update.
- R11: A cycle with `op_valid`=0, or with `op_unit`=3, changes no bypass register and commits nothing to the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_unit | input | 2 | Unit select: 0 adder, 1 shifter, 2 logic, 3 idle |
| op_code | input | 2 | Opcode within the selected unit |
| op_dst | input | log2(REG_COUNT) | Destination register index |
| op_src_a | input | log2(REG_COUNT)+1 | Operand A selector |
| op_src_b | input | log2(REG_COUNT)+1 | Operand B selector |
| res_valid | output | 1 | A result is presented this cycle |
| res_data | output | DATA_W | Result of the operation issued one cycle earlier |

## Verification
Each result is due on `res_data` exactly one cycle after its operation is driven. A register-file commit becomes visible only to an operation issued two cycles after the producer, and a bypass update becomes visible to the very next operation. The bench drives each operation after a falling edge, samples the outputs at the following falling edge, and then updates its reference model in the same order: reads first, then commit of the pending slot, then loading of the new pending entry and the bypass register. Because of this ordering, every stale read, every bypass read and every write-back that lands one cycle later is predicted for the exact cycle in which it can be seen.

// File: rtl/bx_pkg.sv
package bx_pkg;
   localparam int NUM_UNITS = 3;

   typedef enum logic [1:0] {
      UNIT_ADD  = 2'd0,
      UNIT_SHF  = 2'd1,
      UNIT_LOG  = 2'd2,
      UNIT_IDLE = 2'd3
   } unit_e;

   localparam logic [1:0] ADD_AB  = 2'd0;
   localparam logic [1:0] SUB_AB  = 2'd1;
   localparam logic [1:0] SUB_BA  = 2'd2;
   localparam logic [1:0] ADD_AB1 = 2'd3;

   localparam logic [1:0] SHF_SLL = 2'd0;
   localparam logic [1:0] SHF_SRL = 2'd1;
   localparam logic [1:0] SHF_SRA = 2'd2;
   localparam logic [1:0] SHF_ROL = 2'd3;

   localparam logic [1:0] LOG_AND = 2'd0;
   localparam logic [1:0] LOG_OR  = 2'd1;
   localparam logic [1:0] LOG_XOR = 2'd2;
   localparam logic [1:0] LOG_NOR = 2'd3;
endpackage

// File: rtl/bx_operand_sel.sv
module bx_operand_sel #(
   parameter int DATA_W    = 16,
   parameter int REG_COUNT = 8,
   parameter int NUM_BYP   = 3,
   localparam int IDX_W    = $clog2(REG_COUNT)
) (
   input  logic [IDX_W:0]                     sel,
   input  logic [REG_COUNT-1:0][DATA_W-1:0]   rf,
   input  logic [NUM_BYP-1:0][DATA_W-1:0]     byp,
   output logic [DATA_W-1:0]                  val
);
   // four bypass slots addressed by two bits; absent units read zero (R5)
   logic [3:0][DATA_W-1:0] byp_ext;

   for (genvar k = 0; k < 4; k++) begin : g_slot
      if (k < NUM_BYP) begin : g_live
         assign byp_ext[k] = byp[k];
      end else begin : g_zero
         assign byp_ext[k] = '0;
      end
   end

   always_comb begin
      if (sel[IDX_W]) val = byp_ext[sel[1:0]];
      else            val = rf[sel[IDX_W-1:0]];
   end
endmodule

// File: rtl/bx_adder.sv
module bx_adder
   import bx_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [1:0]        code,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);
   always_comb begin
      unique case (code)
         ADD_AB:  y = a + b;
         SUB_AB:  y = a - b;
         SUB_BA:  y = b - a;
         default: y = a + b + DATA_W'(1);
      endcase
   end
endmodule

// File: rtl/bx_shifter.sv
module bx_shifter
   import bx_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter bit SHIFT_STAGED = 1'b1,
   localparam int SH_W        = $clog2(DATA_W)
) (
   input  logic [1:0]        code,
   input  logic [DATA_W-1:0] a,
   input  logic [SH_W-1:0]   amt,
   output logic [DATA_W-1:0] y
);
   if (SHIFT_STAGED) begin : g_staged
      // one conditional stage per amount bit, stage s moves by 2**s
      always_comb begin
         logic [DATA_W-1:0] st;
         st = a;
         for (int s = 0; s < SH_W; s++) begin
            if (amt[s]) begin
               unique case (code)
                  SHF_SLL: st = st << (1 << s);
                  SHF_SRL: st = st >> (1 << s);
                  SHF_SRA: st = $unsigned($signed(st) >>> (1 << s));
                  default: st = (st << (1 << s)) | (st >> (DATA_W - (1 << s)));
               endcase
            end
         end
         y = st;
      end
   end else begin : g_direct
      always_comb begin
         unique case (code)
            SHF_SLL: y = a << amt;
            SHF_SRL: y = a >> amt;
            SHF_SRA: y = $unsigned($signed(a) >>> amt);
            default: y = (amt == '0) ? a
                         : ((a << amt) | (a >> (DATA_W - int'(amt))));
         endcase
      end
   end

   always_comb begin
      if (amt == '0) assert_zero_shift_R3: assert (y == a);
   end
endmodule

// File: rtl/bx_logic.sv
module bx_logic
   import bx_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [1:0]        code,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);
   always_comb begin
      unique case (code)
         LOG_AND: y = a & b;
         LOG_OR:  y = a | b;
         LOG_XOR: y = a ^ b;
         default: y = ~(a | b);
      endcase
   end
endmodule

// File: rtl/bx_alu_stage.sv
module bx_alu_stage
   import bx_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int REG_COUNT    = 8,
   parameter bit SHIFT_STAGED = 1'b1,
   localparam int IDX_W       = $clog2(REG_COUNT),
   localparam int SEL_W       = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              op_valid,
   input  logic [1:0]        op_unit,
   input  logic [1:0]        op_code,
   input  logic [IDX_W-1:0]  op_dst,
   input  logic [SEL_W-1:0]  op_src_a,
   input  logic [SEL_W-1:0]  op_src_b,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data
);
   localparam int SH_W = $clog2(DATA_W);

   if (DATA_W < 4 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("bx_alu_stage: DATA_W must be a power of two of at least 4");
   end
   if (REG_COUNT < 4 || (REG_COUNT & (REG_COUNT - 1)) != 0) begin : g_bad_depth
      $error("bx_alu_stage: REG_COUNT must be a power of two of at least 4");
   end

   logic [REG_COUNT-1:0][DATA_W-1:0] rf;
   logic [NUM_UNITS-1:0][DATA_W-1:0] byp;
   logic                             wb_vld;
   logic [IDX_W-1:0]                 wb_idx;
   logic [DATA_W-1:0]                wb_data;

   logic              issue;
   logic [DATA_W-1:0] opa, opb, y_add, y_shf, y_log, y_sel;

   assign issue = op_valid && (unit_e'(op_unit) != UNIT_IDLE);

   bx_operand_sel #(.DATA_W(DATA_W), .REG_COUNT(REG_COUNT), .NUM_BYP(NUM_UNITS)) u_sel_a (
      .sel(op_src_a), .rf(rf), .byp(byp), .val(opa));
   bx_operand_sel #(.DATA_W(DATA_W), .REG_COUNT(REG_COUNT), .NUM_BYP(NUM_UNITS)) u_sel_b (
      .sel(op_src_b), .rf(rf), .byp(byp), .val(opb));

   bx_adder #(.DATA_W(DATA_W)) u_add (
      .code(op_code), .a(opa), .b(opb), .y(y_add));
   bx_shifter #(.DATA_W(DATA_W), .SHIFT_STAGED(SHIFT_STAGED)) u_shf (
      .code(op_code), .a(opa), .amt(opb[SH_W-1:0]), .y(y_shf));
   bx_logic #(.DATA_W(DATA_W)) u_log (
      .code(op_code), .a(opa), .b(opb), .y(y_log));

   always_comb begin
      unique case (unit_e'(op_unit))
         UNIT_ADD: y_sel = y_add;
         UNIT_SHF: y_sel = y_shf;
         default:  y_sel = y_log;
      endcase
   end

   // bypass registers, pending write-back slot and result port
   always_ff @(posedge clk) begin
      if (rst) begin
         byp       <= '0;
         wb_vld    <= 1'b0;
         wb_idx    <= '0;
         wb_data   <= '0;
         res_valid <= 1'b0;
         res_data  <= '0;
      end else begin
         for (int u = 0; u < NUM_UNITS; u++) begin
            if (issue && op_unit == 2'(u)) byp[u] <= y_sel;
         end
         wb_vld    <= issue;
         res_valid <= issue;
         if (issue) begin
            wb_idx   <= op_dst;
            wb_data  <= y_sel;
            res_data <= y_sel;
         end
      end
   end

   // register file: commits the slot one cycle after issue
   always_ff @(posedge clk) begin
      if (rst)         rf <= '0;
      else if (wb_vld) rf[wb_idx] <= wb_data;
   end

   assert_rst_clear_R1: assert property (@(posedge clk)
      rst |=> (rf == '0 && byp == '0 && !wb_vld && !res_valid));

   assert_res_issue_R6: assert property (@(posedge clk) disable iff (rst)
      issue |=> res_valid);
   assert_res_quiet_R6: assert property (@(posedge clk) disable iff (rst)
      !issue |=> !res_valid);

   assert_wb_commit_R8: assert property (@(posedge clk) disable iff (rst)
      wb_vld |=> rf[$past(wb_idx)] == $past(wb_data));

   assert_wb_follow_R9: assert property (@(posedge clk) disable iff (rst)
      issue |=> (wb_vld && wb_idx == $past(op_dst)));

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_hold
      assert_byp_hold_R7: assert property (@(posedge clk) disable iff (rst)
         !(issue && op_unit == 2'(u)) |=> $stable(byp[u]));
   end
endmodule

// File: tb/bx_alu_stage_bench.sv
`timescale 1ns/1ps
module bx_alu_stage_bench;
   localparam int W = 16;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        op_valid = 1'b0;
   logic [1:0]  op_unit = 2'd3;
   logic [1:0]  op_code = 2'd0;
   logic [2:0]  op_dst = 3'd0;
   logic [3:0]  op_src_a = 4'd0;
   logic [3:0]  op_src_b = 4'd0;
   logic        res_valid;
   logic [W-1:0] res_data;

   int n_chk = 0;
   int n_fail = 0;

   logic [W-1:0] m_rf [N];
   logic [W-1:0] m_byp [3];
   logic         m_pv;
   logic [2:0]   m_pidx;
   logic [W-1:0] m_pd;

   always #10 clk = ~clk;

   bx_alu_stage u_bx_alu_stage (
      .clk(clk), .rst(rst), .op_valid(op_valid), .op_unit(op_unit),
      .op_code(op_code), .op_dst(op_dst), .op_src_a(op_src_a),
      .op_src_b(op_src_b), .res_valid(res_valid), .res_data(res_data));

   function automatic logic [3:0] rs(int i);
      return {1'b0, 3'(i)};
   endfunction
   function automatic logic [3:0] bs(int u);
      return {2'b10, 2'(u)};
   endfunction

   function automatic logic [W-1:0] rd(logic [3:0] s);
      if (s[3]) return (s[1:0] == 2'd3) ? '0 : m_byp[s[1:0]];
      return m_rf[s[2:0]];
   endfunction

   function automatic logic [W-1:0] ref_alu(logic [1:0] u, logic [1:0] c,
                                            logic [W-1:0] a, logic [W-1:0] b);
      int k;
      k = int'(b[3:0]);
      case (u)
         2'd0: case (c)
            2'd0: return a + b;
            2'd1: return a - b;
            2'd2: return b - a;
            default: return a + b + 16'd1;
         endcase
         2'd1: case (c)
            2'd0: return a << k;
            2'd1: return a >> k;
            2'd2: return $unsigned($signed(a) >>> k);
            default: return (k == 0) ? a : ((a << k) | (a >> (W - k)));
         endcase
         default: case (c)
            2'd0: return a & b;
            2'd1: return a | b;
            2'd2: return a ^ b;
            default: return ~(a | b);
         endcase
      endcase
   endfunction

   task automatic check(input bit ok, input string tag,
                        input logic [W-1:0] got, input logic [W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // drive at a falling edge, result checked at the next falling edge
   task automatic run_op(input logic v, input logic [1:0] u, input logic [1:0] c,
                         input logic [2:0] d, input logic [3:0] sa,
                         input logic [3:0] sb, input string tag,
                         output logic [W-1:0] got);
      logic [W-1:0] exp;
      logic         ev;
      op_valid = v; op_unit = u; op_code = c; op_dst = d;
      op_src_a = sa; op_src_b = sb;
      ev  = v && (u != 2'd3);
      exp = ref_alu(u, c, rd(sa), rd(sb));
      if (m_pv) m_rf[m_pidx] = m_pd;
      m_pv = ev; m_pidx = d; m_pd = exp;
      if (ev) m_byp[u] = exp;
      @(negedge clk);
      got = res_data;
      if (ev) check(res_valid === 1'b1 && res_data === exp, tag, res_data, exp);
      else    check(res_valid === 1'b0, tag, {15'd0, res_valid}, '0);
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [W-1:0] g1, g2, g3, old;
      void'($urandom(32'h5EED_0B1A));
      for (int i = 0; i < N; i++) m_rf[i] = '0;
      for (int i = 0; i < 3; i++) m_byp[i] = '0;
      m_pv = 1'b0; m_pidx = '0; m_pd = '0;

      repeat (3) @(negedge clk);
      check(res_valid === 1'b0, "R1 res_valid in reset", {15'd0, res_valid}, '0);
      rst = 1'b0;

      // R1: every register and bypass reads zero after reset
      for (int i = 0; i < N; i++) run_op(1, 2, 1, 3'(i), rs(i), rs(i), "R1 rf zero", g1);
      run_op(1, 2, 1, 0, bs(0), bs(1), "R1 bypass zero", g1);

      // R5: bypass code 3 reads zero; build nonzero values from zeros
      run_op(1, 2, 3, 1, rs(0), rs(0), "R4 nor of zeros", g1);
      run_op(1, 2, 1, 2, bs(3), bs(3), "R5 bypass code 3 is zero", g1);
      run_op(1, 0, 3, 2, rs(0), rs(0), "R2 add plus one", g1);
      run_op(1, 1, 3, 4, bs(2), bs(0), "R3 rotate by one", g1);
      run_op(1, 1, 0, 5, bs(2), rs(0), "R3 zero shift keeps A", g1);

      // random mix
      for (int i = 0; i < 600; i++) begin
         logic [1:0] u, c;
         logic [3:0] sa, sb;
         logic       v;
         v  = ($urandom_range(0, 9) != 0);
         u  = 2'($urandom_range(0, 3));
         c  = 2'($urandom_range(0, 3));
         sa = ($urandom_range(0, 2) == 0) ? bs($urandom_range(0, 3)) : rs($urandom_range(0, 7));
         sb = ($urandom_range(0, 2) == 0) ? bs($urandom_range(0, 3)) : rs($urandom_range(0, 7));
         run_op(v, u, c, 3'($urandom_range(0, 7)), sa, sb,
                (!v || u == 2'd3) ? "R11 random idle"
                : (u == 2'd0) ? "R2 random adder"
                : (u == 2'd1) ? "R3 random shifter" : "R4 random logic", g1);
      end

      // R8: stale read one cycle after issue, new value two cycles after
      old = m_rf[3];
      run_op(1, 2, 3, 3, rs(0), rs(0), "R8 producer", g1);
      run_op(1, 2, 1, 6, rs(3), rs(3), "R8 read at N+1", g2);
      check(g2 === old, "R8 stale value at N+1", g2, old);
      run_op(1, 2, 1, 6, rs(3), rs(3), "R8 read at N+2", g3);
      check(g3 === g1, "R8 new value at N+2", g3, g1);

      // R9: back-to-back same destination, then an idle gap
      run_op(1, 0, 0, 2, rs(1), rs(4), "R9 first write", g1);
      run_op(1, 0, 1, 2, rs(1), rs(4), "R9 second write", g2);
      run_op(0, 0, 0, 2, rs(0), rs(0), "R9 idle gap", g3);
      run_op(1, 2, 1, 7, rs(2), rs(2), "R9 later result kept", g3);
      check(g3 === g2, "R9 later result kept", g3, g2);

      // R7: other unit leaves the adder bypass alone
      run_op(1, 0, 3, 1, rs(5), rs(6), "R7 adder op", g1);
      run_op(1, 1, 1, 1, rs(5), rs(6), "R7 shifter op", g2);
      run_op(1, 2, 1, 0, bs(0), bs(0), "R7 adder bypass held", g3);
      check(g3 === g1, "R7 adder bypass held", g3, g1);

      // R10: reading a bypass in the cycle it is reloaded returns old value
      old = m_byp[0];
      run_op(1, 0, 0, 4, bs(0), bs(0), "R10 self bypass read", g1);
      check(g1 === 16'(old + old), "R10 pre-update operands", g1, 16'(old + old));

      // R11 and R6: idle cycles leave bypasses and the register file untouched
      old = m_byp[1];
      run_op(1, 3, 0, 5, rs(1), rs(2), "R11 unit 3 idle", g1);
      run_op(0, 1, 2, 5, rs(1), rs(2), "R6 valid low no result", g1);
      run_op(1, 2, 1, 0, bs(1), bs(1), "R11 shifter bypass intact", g1);
      check(g1 === old, "R11 shifter bypass intact", g1, old);
      run_op(1, 2, 1, 0, rs(5), rs(5), "R11 rf entry not written", g1);

      op_valid = 1'b0;
      @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule